// File: doc/BRIEF.md
# Geometric History Adder Predictor

This block guesses the direction of conditional branches. It keeps several tables of small signed counters. Each table is indexed by the branch address mixed with a slice of the global branch history, and each table uses a longer slice than the one before it. The slice lengths grow geometrically, so the short tables learn per-address bias and the long tables learn correlations with outcomes far back in the history. A prediction adds one counter from every table to a fixed bias. The sign of that total gives the direction.

The front end issues a predict request with the branch address and gets the direction and the vote total one cycle later. When the branch resolves, the back end sends an update with the same address and the real outcome. Updates come in program order. An update re-reads the same counters under the history that was current before its own outcome is added. If the total pointed the wrong way, or was too close to zero, every counter that was read takes one saturating step toward the outcome. The outcome is then shifted into the history register.

Top module: `geo_vote_predictor`

## Requirements
- R1: After reset every counter is 0 and the 16-bit history register `ghr_o` is 0. The first prediction therefore has a total of 2 and says taken, and `pred_valid_o` is low until the first request.
- R2: A predict request sampled at a clock edge shows on `pred_valid_o`, `pred_taken_o` and `pred_sum_o` right after that edge. In a cycle without a request, `pred_valid_o` is low and the other two outputs hold their values.
- R3: The total is 2 (half the table count of 4) plus the four counters that were read, as a signed value. Taken (`pred_taken_o` = 1) is reported exactly when the total is zero or more.
- R4: Table t is indexed by the address bits [7:2] XOR a 6-bit fold of the low L(t) history bits. The lengths L are 0, 4, 8 and 16. The fold XORs history bits [5:0], [11:6] and [15:12] together, with the bits at or above L(t) treated as zero.
- R5: An update trains the counters only when it was mispredicted (its recomputed total has the wrong sign for the outcome) or when the total lies strictly between -4 and +4. Otherwise the counters are left unchanged.
- R6: During training, each of the four counters that were read moves up by one for taken or down by one for not taken. A counter saturates at +7 and -8.
- R7: Every update shifts the history left by one and puts the outcome in bit 0 (1 = taken).
- R8: An update uses the history and counters as they stood before that update. A prediction issued in the same cycle as an update sees the state before that update.
- R9: In cycles with no update, the history and the counters do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Predict request |
| pred_pc_i | input | 32 | Branch address for the prediction |
| upd_valid_i | input | 1 | Resolved-branch update |
| upd_pc_i | input | 32 | Branch address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_sum_o | output | 7 | Signed vote total behind the prediction |
| ghr_o | output | 16 | Global history register |

## Verification
The bench builds the block with its default parameters: four tables of 64 counters, 4-bit counters, and history lengths 0, 4, 8 and 16. With only eight random branch addresses, entries alias heavily across many histories. Outcomes biased per address then push the address-only table to both saturation limits, while the longer tables see a wide spread of folded indices. The bench also drives predictions and updates in the same cycle and inserts idle gaps. Because every total is compared against a bench model, a fault in the confidence window, the fold, the saturation or the update ordering shows up as a wrong total.

// File: rtl/gvp_pkg.sv
`timescale 1ns/1ps
package gvp_pkg;

  // history length of table tbl: 0 for table 0, then base*growth^(tbl-1)
  function automatic int hist_len(int tbl, int base, int growth);
    int r;
    if (tbl == 0) return 0;
    r = base;
    for (int i = 1; i < tbl; i++) r = r * growth;
    return r;
  endfunction

endpackage

// File: rtl/gvp_index_hash.sv
`timescale 1ns/1ps
module gvp_index_hash #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 16,
  parameter int HLEN   = 4
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  idx_o
);

  logic [IDX_W-1:0] folded;
  logic             unused_pc;

  assign unused_pc = ^{pc_i[PC_W-1:PC_LSB+IDX_W], pc_i[PC_LSB-1:0]};

  always_comb begin
    folded = '0;
    for (int k = 0; k < HIST_W; k++) begin
      if (k < HLEN) folded[k % IDX_W] = folded[k % IDX_W] ^ hist_i[k];
    end
    idx_o = pc_i[PC_LSB +: IDX_W] ^ folded;
  end

endmodule

// File: rtl/gvp_counter_table.sv
`timescale 1ns/1ps
module gvp_counter_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_a_i,
  output logic [CTR_W-1:0] ctr_a_o,
  input  logic [IDX_W-1:0] rd_idx_b_i,
  output logic [CTR_W-1:0] ctr_b_o,
  input  logic             wr_en_i,
  input  logic             wr_inc_i
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic [CTR_W-1:0] CMIN = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic [CTR_W-1:0] ONE  = {{(CTR_W-1){1'b0}}, 1'b1};

  logic [CTR_W-1:0] mem_q [DEPTH];
  logic [CTR_W-1:0] nxt;

  assign ctr_a_o = mem_q[rd_idx_a_i];
  assign ctr_b_o = mem_q[rd_idx_b_i];

  // saturating step toward the outcome
  always_comb begin
    nxt = ctr_b_o;
    if (wr_inc_i && (ctr_b_o != CMAX))       nxt = ctr_b_o + ONE;
    else if (!wr_inc_i && (ctr_b_o != CMIN)) nxt = ctr_b_o - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else if (wr_en_i) begin
      mem_q[rd_idx_b_i] <= nxt;
    end
  end

endmodule

// File: rtl/gvp_vote_sum.sv
`timescale 1ns/1ps
module gvp_vote_sum #(
  parameter int N     = 4,
  parameter int CTR_W = 4,
  parameter int SUM_W = 7,
  parameter int BIAS  = 2
) (
  input  logic [N-1:0][CTR_W-1:0] ctrs_i,
  output logic signed [SUM_W-1:0] sum_o
);

  always_comb begin
    sum_o = SUM_W'(BIAS);
    for (int t = 0; t < N; t++) begin
      sum_o = sum_o + SUM_W'($signed(ctrs_i[t]));
    end
  end

endmodule

// File: rtl/geo_vote_predictor.sv
`timescale 1ns/1ps
module geo_vote_predictor #(
  parameter int NUM_TABLES = 4,
  parameter int IDX_W      = 6,
  parameter int CTR_W      = 4,
  parameter int HIST_W     = 16,
  parameter int BASE_LEN   = 4,
  parameter int GROWTH     = 2,
  parameter int PC_W       = 32,
  parameter int PC_LSB     = 2,
  localparam int SUM_W     = CTR_W + $clog2(NUM_TABLES) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pred_valid_i,
  input  logic [PC_W-1:0]         pred_pc_i,
  input  logic                    upd_valid_i,
  input  logic [PC_W-1:0]         upd_pc_i,
  input  logic                    upd_taken_i,
  output logic                    pred_valid_o,
  output logic                    pred_taken_o,
  output logic signed [SUM_W-1:0] pred_sum_o,
  output logic [HIST_W-1:0]       ghr_o
);

  localparam int BIAS = NUM_TABLES / 2;
  localparam logic signed [SUM_W-1:0] THR_P = SUM_W'(NUM_TABLES);
  localparam logic signed [SUM_W-1:0] THR_N = -THR_P;

  logic [HIST_W-1:0]                   ghr_q;
  logic [NUM_TABLES-1:0][CTR_W-1:0]    ctr_pred, ctr_upd;
  logic signed [SUM_W-1:0]             sum_pred, sum_upd;
  logic                                mispred, low_conf, train;
  logic                                pred_valid_q, pred_taken_q;
  logic signed [SUM_W-1:0]             pred_sum_q;

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    localparam int HLEN = gvp_pkg::hist_len(t, BASE_LEN, GROWTH);
    logic [IDX_W-1:0] idx_pred, idx_upd;

    gvp_index_hash #(
      .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W), .HLEN(HLEN)
    ) u_hash_pred (
      .pc_i(pred_pc_i), .hist_i(ghr_q), .idx_o(idx_pred)
    );

    gvp_index_hash #(
      .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W), .HLEN(HLEN)
    ) u_hash_upd (
      .pc_i(upd_pc_i), .hist_i(ghr_q), .idx_o(idx_upd)
    );

    gvp_counter_table #(
      .IDX_W(IDX_W), .CTR_W(CTR_W)
    ) u_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_a_i(idx_pred),
      .ctr_a_o   (ctr_pred[t]),
      .rd_idx_b_i(idx_upd),
      .ctr_b_o   (ctr_upd[t]),
      .wr_en_i   (train),
      .wr_inc_i  (upd_taken_i)
    );
  end

  gvp_vote_sum #(
    .N(NUM_TABLES), .CTR_W(CTR_W), .SUM_W(SUM_W), .BIAS(BIAS)
  ) u_sum_pred (
    .ctrs_i(ctr_pred), .sum_o(sum_pred)
  );

  gvp_vote_sum #(
    .N(NUM_TABLES), .CTR_W(CTR_W), .SUM_W(SUM_W), .BIAS(BIAS)
  ) u_sum_upd (
    .ctrs_i(ctr_upd), .sum_o(sum_upd)
  );

  // train on wrong sign or a total inside the confidence window
  assign mispred  = (!sum_upd[SUM_W-1]) != upd_taken_i;
  assign low_conf = (sum_upd < THR_P) && (sum_upd > THR_N);
  assign train    = upd_valid_i && (mispred || low_conf);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ghr_q        <= '0;
      pred_valid_q <= 1'b0;
      pred_taken_q <= 1'b0;
      pred_sum_q   <= '0;
    end else begin
      pred_valid_q <= pred_valid_i;
      if (pred_valid_i) begin
        pred_taken_q <= !sum_pred[SUM_W-1];
        pred_sum_q   <= sum_pred;
      end
      if (upd_valid_i) ghr_q <= {ghr_q[HIST_W-2:0], upd_taken_i};
    end
  end

  assign pred_valid_o = pred_valid_q;
  assign pred_taken_o = pred_taken_q;
  assign pred_sum_o   = pred_sum_q;
  assign ghr_o        = ghr_q;

endmodule

// File: rtl/gvp_checker.sv
`timescale 1ns/1ps
module gvp_checker #(
  parameter int NUM_TABLES = 4,
  parameter int CTR_W      = 4,
  parameter int HIST_W     = 16,
  localparam int SUM_W     = CTR_W + $clog2(NUM_TABLES) + 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    pred_valid_i,
  input logic                    upd_valid_i,
  input logic                    upd_taken_i,
  input logic                    pred_valid_o,
  input logic                    pred_taken_o,
  input logic signed [SUM_W-1:0] pred_sum_o,
  input logic [HIST_W-1:0]       ghr_o
);

  localparam int SMAX = NUM_TABLES / 2 + NUM_TABLES * (2 ** (CTR_W - 1) - 1);
  localparam int SMIN = NUM_TABLES / 2 - NUM_TABLES * (2 ** (CTR_W - 1));
  localparam logic signed [SUM_W-1:0] SMAX_P = SUM_W'(SMAX);
  localparam logic signed [SUM_W-1:0] SMIN_P = SUM_W'(SMIN);

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i |=> pred_valid_o);

  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i |=> (!pred_valid_o && $stable(pred_sum_o) && $stable(pred_taken_o)));

  p_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (pred_taken_o == (pred_sum_o >= 0)));

  p_sum_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (pred_sum_o <= SMAX_P && pred_sum_o >= SMIN_P));

  p_ghr_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghr_o == {$past(ghr_o[HIST_W-2:0]), $past(upd_taken_i)});

  p_ghr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_o));

endmodule

bind geo_vote_predictor gvp_checker #(
  .NUM_TABLES(NUM_TABLES), .CTR_W(CTR_W), .HIST_W(HIST_W)
) u_gvp_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pred_valid_i(pred_valid_i),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .pred_valid_o(pred_valid_o),
  .pred_taken_o(pred_taken_o),
  .pred_sum_o  (pred_sum_o),
  .ghr_o       (ghr_o)
);

// File: tb/geo_vote_predictor_tb_top.sv
`timescale 1ns/1ps
module geo_vote_predictor_tb_top;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pred_valid_i = 1'b0;
  logic [31:0]       pred_pc_i = '0;
  logic              upd_valid_i = 1'b0;
  logic [31:0]       upd_pc_i = '0;
  logic              upd_taken_i = 1'b0;
  logic              pred_valid_o;
  logic              pred_taken_o;
  logic signed [6:0] pred_sum_o;
  logic [15:0]       ghr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  int          mctr [4][64];
  logic [15:0] mghr;
  bit          exp_pv;
  int          exp_sum;
  bit          exp_tk;

  always #2 clk_i = ~clk_i;

  geo_vote_predictor dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pred_valid_i(pred_valid_i),
    .pred_pc_i   (pred_pc_i),
    .upd_valid_i (upd_valid_i),
    .upd_pc_i    (upd_pc_i),
    .upd_taken_i (upd_taken_i),
    .pred_valid_o(pred_valid_o),
    .pred_taken_o(pred_taken_o),
    .pred_sum_o  (pred_sum_o),
    .ghr_o       (ghr_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tbl_len(int t);
    return (t == 0) ? 0 : (4 << (t - 1));
  endfunction

  function automatic int tbl_idx(int t, logic [31:0] pc, logic [15:0] h);
    int m;
    int f;
    m = int'(h) & ((1 << tbl_len(t)) - 1);
    f = (m ^ (m >> 6) ^ (m >> 12)) & 63;
    return (int'(pc >> 2) & 63) ^ f;
  endfunction

  function automatic int model_sum(logic [31:0] pc);
    int s = 2;
    for (int t = 0; t < 4; t++) s += mctr[t][tbl_idx(t, pc, mghr)];
    return s;
  endfunction

  task automatic model_update(logic [31:0] pc, bit tk);
    int s;
    bit wrong;
    s = model_sum(pc);
    wrong = (s >= 0) != tk;
    if (wrong || (s > -4 && s < 4)) begin
      for (int t = 0; t < 4; t++) begin
        int i = tbl_idx(t, pc, mghr);
        if (tk && mctr[t][i] < 7) mctr[t][i]++;
        else if (!tk && mctr[t][i] > -8) mctr[t][i]--;
      end
    end
    mghr = {mghr[14:0], tk};
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(bit pv, logic [31:0] ppc, bit uv, logic [31:0] upc, bit ut);
    pred_valid_i = pv;
    pred_pc_i    = ppc;
    upd_valid_i  = uv;
    upd_pc_i     = upc;
    upd_taken_i  = ut;
    exp_pv = pv;
    if (pv) begin
      exp_sum = model_sum(ppc);
      exp_tk  = exp_sum >= 0;
    end
    if (uv) model_update(upc, ut);
    @(negedge clk_i);
    check("R2 valid", int'(pred_valid_o), int'(exp_pv));
    check("R3/R4/R5/R6/R8 sum", int'(pred_sum_o), exp_sum);
    check("R3 direction", int'(pred_taken_o), int'(exp_tk));
    check("R7/R9 history", int'(ghr_o), int'(mghr));
  endtask

  initial begin
    logic [31:0] pool [8];
    void'($urandom(32'd20240611));
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 64; i++) mctr[t][i] = 0;
    mghr = '0;
    exp_pv = 0; exp_sum = 0; exp_tk = 0;

    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", int'(pred_valid_o), 0);
    check("R1 history in reset", int'(ghr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: first prediction from cleared tables
    step(1, 32'h0000_1040, 0, 0, 0);
    check("R1 first sum", int'(pred_sum_o), 2);
    check("R1 first taken", int'(pred_taken_o), 1);
    // R5: low-confidence correct update trains
    step(0, 0, 1, 32'h0000_1040, 1);
    step(1, 32'h0000_1040, 0, 0, 0);
    // R8: predict and update in the same cycle
    step(1, 32'h0000_2080, 1, 32'h0000_2080, 0);
    step(1, 32'h0000_2080, 0, 0, 0);
    // R9: idle cycles leave state alone, R2 holds outputs
    repeat (3) step(0, 0, 0, 0, 0);
    step(1, 32'h0000_2080, 0, 0, 0);

    // R6: one address always taken, another never, to drive saturation
    for (int n = 0; n < 300; n++) begin
      bit pick = ($urandom % 3) != 0;
      step(1, 32'h0000_30c0, 1, pick ? 32'h0000_30c0 : 32'h0000_4104, pick);
    end
    for (int n = 0; n < 300; n++) begin
      step(1, 32'h0000_30c0, 1, 32'h0000_30c0, ($urandom % 5) == 0);
    end

    // mixed random traffic over a small address pool
    for (int i = 0; i < 8; i++) pool[i] = $urandom;
    for (int n = 0; n < 6000; n++) begin
      int a = $urandom % 8;
      int b = $urandom % 8;
      int bias = (b % 2 == 0) ? 85 : 20;
      step(($urandom % 4) != 0, pool[a], ($urandom % 3) != 0, pool[b],
           ($urandom % 100) < bias);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule